// File: doc/BRIEF.md
# Fractional baud rate generator

This block derives the timing strobes for a serial port from the system clock. In asynchronous operation an integer divisor plus a fraction in eighths sets the oversample strobe period. A bit strobe follows every 16 or every 8 oversample strobes, as chosen by one input. Each fractional step stretches one divider period in eight by one extra clock cycle, so the average oversample period is cd + fp/8 clock cycles.

In the two synchronous master modes the fraction and the oversampling are bypassed. The bit strobe then comes every cd clock cycles, and a divided serial clock is driven on `sck_o`. In external-clock mode the block takes its bit timing from an external serial clock pin. That pin is synchronised into the system clock domain, and each rising edge produces one strobe. Software computes the divisor; the block only applies it. When any configuration input changes, the counters restart from zero.

Top module: `baud_gen`

## Requirements
- R1: While rst_ni is low, os_tick_o, bit_tick_o and sck_o are all low.
- R2: In asynchronous mode (mode_i = 2'b00) with fp_i = 0, os_tick_o pulses for one cycle every cd_i clock cycles, and sck_o stays low.
- R3: In asynchronous mode each gap between oversample strobes is cd_i or cd_i+1 cycles. Any 8 consecutive gaps add up to exactly 8*cd_i + fp_i cycles.
- R4: In asynchronous mode bit_tick_o pulses only together with os_tick_o. The bit period is 16*cd_i + 2*fp_i cycles when over8_i = 0, and 8*cd_i + fp_i cycles when over8_i = 1.
- R5: With cd_i = 0 in asynchronous or synchronous master mode, no strobe is produced and sck_o stays low.
- R6: In synchronous master mode (mode_i = 2'b01), os_tick_o and bit_tick_o pulse together every cd_i cycles, and fp_i is ignored. sck_o is high for cd_i - floor(cd_i/2) cycles of each period.
- R7: In the serial-peripheral master mode (mode_i = 2'b10), a cd_i below 4 silences all outputs. A cd_i of 4 or more behaves as in R6.
- R8: In external-clock mode (mode_i = 2'b11), each rising edge on ext_sck_i yields exactly one pulse on both os_tick_o and bit_tick_o. There are no pulses without edges, and sck_o stays low.
- R9: A change on any of cd_i, fp_i, over8_i or mode_i restarts the divider. In a divided mode the first os_tick_o is seen exactly cd_i rising clock edges after the configuration was applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cd_i | input | CD_W | Integer divisor |
| fp_i | input | FP_W | Fraction in eighths of a clock cycle |
| over8_i | input | 1 | 1 selects 8x oversampling, 0 selects 16x |
| mode_i | input | 2 | 00 async, 01 sync master, 10 serial-peripheral master, 11 external clock |
| ext_sck_i | input | 1 | External serial clock |
| os_tick_o | output | 1 | Oversample strobe |
| bit_tick_o | output | 1 | Bit strobe |
| sck_o | output | 1 | Divided serial clock in the synchronous master modes |

## Verification
Assertions check on every cycle that outputs stay quiet with an illegal divisor or while a restart is pending. They also check that a bit strobe is always paired with an oversample strobe, and that the synchronous modes keep both strobes in lockstep. The cycle-exact gaps, the eighth-step spreading over eight periods, the bit period under both oversampling factors, the restart latency and the edge-to-strobe count in external mode need sequences of periods. Only the bench scenarios show those.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
  typedef enum logic [1:0] {
    MODE_ASYNC = 2'b00,
    MODE_SYNC  = 2'b01,
    MODE_SPI   = 2'b10,
    MODE_EXT   = 2'b11
  } clk_mode_e;
endpackage

// File: rtl/baud_frac_div.sv
module baud_frac_div #(
  parameter int CD_W = 16,
  parameter int FP_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            en_i,
  input  logic            frac_en_i,
  input  logic [CD_W-1:0] cd_i,
  input  logic [FP_W-1:0] fp_i,
  output logic            tick_o,
  output logic            sck_o
);
  localparam int CW = CD_W + 1;

  logic [CD_W-1:0] cnt_q, cnt_d;
  logic [FP_W-1:0] acc_q;
  logic [FP_W:0]   acc_sum;
  logic [CW-1:0]   last;
  logic            stretch, run, sck_q;

  assign run     = en_i && !clear_i;
  assign acc_sum = {1'b0, acc_q} + {1'b0, fp_i};
  // carry out of the eighths accumulator stretches this period by one cycle
  assign stretch = frac_en_i && acc_sum[FP_W];
  assign last    = {1'b0, cd_i} - CW'(1) + CW'(stretch);
  assign tick_o  = run && ({1'b0, cnt_q} == last);
  assign cnt_d   = tick_o ? '0 : cnt_q + CD_W'(1);
  assign sck_o   = sck_q && run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      acc_q <= '0;
      sck_q <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      acc_q <= '0;
      sck_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (tick_o && frac_en_i) acc_q <= acc_sum[FP_W-1:0];
      sck_q <= (cnt_d >= (cd_i >> 1));
    end
  end

  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0 && acc_q == '0));

  p_no_frac_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !frac_en_i) |-> ({1'b0, cnt_q} + CW'(1) == {1'b0, cd_i}));
endmodule

// File: rtl/baud_os_count.sv
module baud_os_count #(
  parameter int OS_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic os_tick_i,
  input  logic over8_i,
  output logic bit_tick_o
);
  localparam logic [OS_W-1:0] LIM_FULL = '1;
  localparam logic [OS_W-1:0] LIM_HALF = OS_W'((1 << (OS_W - 1)) - 1);

  logic [OS_W-1:0] cnt_q, lim;

  assign lim        = over8_i ? LIM_HALF : LIM_FULL;
  assign bit_tick_o = !clear_i && os_tick_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (clear_i)   cnt_q <= '0;
    else if (os_tick_i) cnt_q <= (cnt_q == lim) ? '0 : cnt_q + OS_W'(1);
  end

  p_bit_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |=> !bit_tick_o);
endmodule

// File: rtl/baud_ext_sync.sv
module baud_ext_sync #(
  parameter int LEN = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  output logic rise_o
);
  logic [LEN:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[LEN-1:0], sck_i};
  end

  assign rise_o = sh_q[LEN-1] && !sh_q[LEN];
endmodule

// File: rtl/baud_gen.sv
module baud_gen
  import baud_gen_pkg::*;
#(
  parameter int CD_W       = 16,
  parameter int FP_W       = 3,
  parameter int OS_W       = 4,
  parameter int SPI_MIN_CD = 4,
  parameter int SYNC_LEN   = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [CD_W-1:0] cd_i,
  input  logic [FP_W-1:0] fp_i,
  input  logic            over8_i,
  input  logic [1:0]      mode_i,
  input  logic            ext_sck_i,
  output logic            os_tick_o,
  output logic            bit_tick_o,
  output logic            sck_o
);
  clk_mode_e       mode_q;
  logic [CD_W-1:0] cd_q;
  logic [FP_W-1:0] fp_q;
  logic            over8_q;
  logic            restart, cd_ok, div_en;
  logic            div_tick, div_sck, os_bit, ext_rise, ext_tick;

  assign restart = (clk_mode_e'(mode_i) != mode_q) || (cd_i != cd_q) ||
                   (fp_i != fp_q) || (over8_i != over8_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_ASYNC;
      cd_q    <= '0;
      fp_q    <= '0;
      over8_q <= 1'b0;
    end else begin
      mode_q  <= clk_mode_e'(mode_i);
      cd_q    <= cd_i;
      fp_q    <= fp_i;
      over8_q <= over8_i;
    end
  end

  assign cd_ok  = (mode_q == MODE_SPI) ? (cd_q >= CD_W'(SPI_MIN_CD)) : (cd_q != '0);
  assign div_en = cd_ok && (mode_q != MODE_EXT);

  baud_frac_div #(.CD_W(CD_W), .FP_W(FP_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (restart),
    .en_i      (div_en),
    .frac_en_i (mode_q == MODE_ASYNC),
    .cd_i      (cd_q),
    .fp_i      (fp_q),
    .tick_o    (div_tick),
    .sck_o     (div_sck)
  );

  baud_os_count #(.OS_W(OS_W)) u_os (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (restart || (mode_q != MODE_ASYNC)),
    .os_tick_i  (div_tick),
    .over8_i    (over8_q),
    .bit_tick_o (os_bit)
  );

  baud_ext_sync #(.LEN(SYNC_LEN)) u_ext (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sck_i  (ext_sck_i),
    .rise_o (ext_rise)
  );

  assign ext_tick = (mode_q == MODE_EXT) && !restart && ext_rise;

  always_comb begin
    unique case (mode_q)
      MODE_ASYNC: begin
        os_tick_o  = div_tick;
        bit_tick_o = os_bit;
        sck_o      = 1'b0;
      end
      MODE_SYNC, MODE_SPI: begin
        os_tick_o  = div_tick;
        bit_tick_o = div_tick;
        sck_o      = div_sck;
      end
      default: begin
        os_tick_o  = ext_tick;
        bit_tick_o = ext_tick;
        sck_o      = 1'b0;
      end
    endcase
  end

  p_cd_zero_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != MODE_EXT && cd_q == '0) |-> (!os_tick_o && !bit_tick_o && !sck_o));

  p_spi_min_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SPI && cd_q < CD_W'(SPI_MIN_CD)) |-> (!os_tick_o && !sck_o));

  p_bit_in_os_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |-> os_tick_o);

  p_sync_lockstep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SYNC || mode_q == MODE_SPI) |-> (bit_tick_o == os_tick_o));

  p_restart_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |-> (!os_tick_o && !bit_tick_o));

  p_async_sck_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_ASYNC) |-> !sck_o);
endmodule

// File: tb/baud_gen_test.sv
module baud_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cd = 16'd1;
  logic [2:0]  fp = 3'd0;
  logic        over8 = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        ext_sck = 1'b0;
  logic        os_tick, bit_tick, sck;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int n_os = 0, n_bit = 0, n_sck = 0;

  always #5 clk = ~clk;

  baud_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .cd_i(cd), .fp_i(fp), .over8_i(over8),
    .mode_i(mode), .ext_sck_i(ext_sck),
    .os_tick_o(os_tick), .bit_tick_o(bit_tick), .sck_o(sck)
  );

  always @(negedge clk) begin
    n_os  <= n_os + int'(os_tick);
    n_bit <= n_bit + int'(bit_tick);
    n_sck <= n_sck + int'(sck);
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [1:0] m, input logic o8, input int c, input int f);
    @(negedge clk);
    mode = m; over8 = o8; cd = 16'(c); fp = 3'(f);
  endtask

  // count outputs over n clock cycles
  task automatic window(input int n, output int os_c, output int bit_c, output int sck_c);
    int a_os, a_bit, a_sck;
    @(posedge clk);
    a_os = n_os; a_bit = n_bit; a_sck = n_sck;
    repeat (n) @(posedge clk);
    os_c = n_os - a_os; bit_c = n_bit - a_bit; sck_c = n_sck - a_sck;
  endtask

  task automatic wait_hi(input bit use_bit);
    @(negedge clk);
    while (!(use_bit ? bit_tick : os_tick)) @(negedge clk);
  endtask

  task automatic gap(input bit use_bit, output int g);
    g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (!(use_bit ? bit_tick : os_tick));
  endtask

  task automatic gaps8(output int sum, output int mn, output int mx);
    int g;
    sum = 0; mn = 1 << 30; mx = 0;
    wait_hi(1'b0);
    for (int i = 0; i < 8; i++) begin
      gap(1'b0, g);
      sum += g;
      if (g < mn) mn = g;
      if (g > mx) mx = g;
    end
  endtask

  task automatic t_reset;
    int o, b, s;
    window(20, o, b, s);
    check("R1 os during reset", o, 0);
    check("R1 bit during reset", b, 0);
    check("R1 sck during reset", s, 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_async_int;
    int g, o, b, s;
    set_cfg(2'b00, 1'b0, 5, 0);
    wait_hi(1'b0);
    gap(1'b0, g);
    check("R2 os gap cd=5", g, 5);
    wait_hi(1'b1);
    gap(1'b1, g);
    check("R4 bit gap 16x cd=5", g, 80);
    window(200, o, b, s);
    check("R2 sck low in async", s, 0);
    check("R4 bit count matches os/16", b * 16 <= o + 16 && b * 16 >= o - 16 ? 1 : 0, 1);
  endtask

  task automatic t_async_frac;
    int sum, mn, mx, g;
    set_cfg(2'b00, 1'b1, 3, 5);
    gaps8(sum, mn, mx);
    check("R3 sum cd=3 fp=5", sum, 29);
    check("R3 min gap", mn, 3);
    check("R3 max gap", mx, 4);
    wait_hi(1'b1);
    gap(1'b1, g);
    check("R4 bit gap 8x cd=3 fp=5", g, 29);
    set_cfg(2'b00, 1'b0, 2, 7);
    gaps8(sum, mn, mx);
    check("R3 sum cd=2 fp=7", sum, 23);
    wait_hi(1'b1);
    gap(1'b1, g);
    check("R4 bit gap 16x cd=2 fp=7", g, 46);
    set_cfg(2'b00, 1'b0, 1, 4);
    gaps8(sum, mn, mx);
    check("R3 sum cd=1 fp=4", sum, 12);
    check("R3 min gap cd=1", mn, 1);
    wait_hi(1'b1);
    gap(1'b1, g);
    check("R4 bit gap 16x cd=1 fp=4", g, 24);
  endtask

  task automatic t_zero_cd;
    int o, b, s;
    set_cfg(2'b00, 1'b0, 0, 5);
    window(120, o, b, s);
    check("R5 async cd=0 os", o, 0);
    check("R5 async cd=0 bit", b, 0);
    set_cfg(2'b01, 1'b0, 0, 0);
    window(120, o, b, s);
    check("R5 sync cd=0 os", o, 0);
    check("R5 sync cd=0 sck", s, 0);
  endtask

  task automatic t_sync;
    int sum, mn, mx, o, b, s;
    set_cfg(2'b01, 1'b0, 5, 7);
    gaps8(sum, mn, mx);
    check("R6 sync sum cd=5 fp ignored", sum, 40);
    check("R6 sync max gap", mx, 5);
    window(50, o, b, s);
    check("R6 sync os count", o, 10);
    check("R6 sync bit count", b, 10);
    check("R6 sync sck high cd=5", s, 30);
    set_cfg(2'b01, 1'b0, 6, 0);
    repeat (10) @(negedge clk);
    window(60, o, b, s);
    check("R6 sync sck high cd=6", s, 30);
  endtask

  task automatic t_spi;
    int o, b, s, g;
    set_cfg(2'b10, 1'b0, 3, 0);
    window(100, o, b, s);
    check("R7 spi cd=3 os", o, 0);
    check("R7 spi cd=3 sck", s, 0);
    set_cfg(2'b10, 1'b0, 4, 0);
    wait_hi(1'b0);
    gap(1'b0, g);
    check("R7 spi cd=4 gap", g, 4);
    window(40, o, b, s);
    check("R7 spi cd=4 bit count", b, 10);
    check("R7 spi cd=4 sck high", s, 20);
  endtask

  task automatic t_ext;
    int o, b, s, a_os, a_bit, a_sck;
    set_cfg(2'b11, 1'b0, 5, 0);
    repeat (10) @(negedge clk);
    @(posedge clk);
    a_os = n_os; a_bit = n_bit; a_sck = n_sck;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); ext_sck = 1'b1;
      repeat (7) @(negedge clk);
      ext_sck = 1'b0;
      repeat (6) @(negedge clk);
    end
    repeat (10) @(posedge clk);
    check("R8 ext os per edge", n_os - a_os, 10);
    check("R8 ext bit per edge", n_bit - a_bit, 10);
    check("R8 ext sck low", n_sck - a_sck, 0);
    @(negedge clk); ext_sck = 1'b1;
    repeat (10) @(negedge clk);
    window(60, o, b, s);
    check("R8 ext no edge no tick", o, 0);
    ext_sck = 1'b0;
  endtask

  task automatic t_restart_one(input logic [1:0] m, input int c, input int f, input string tag);
    int k;
    set_cfg(m, 1'b0, c, f);
    k = 0;
    do begin
      @(posedge clk);
      k++;
      @(negedge clk);
    end while (!os_tick && k < 1000);
    check(tag, k, c);
  endtask

  task automatic t_restart;
    set_cfg(2'b00, 1'b0, 9, 0);
    repeat (4) @(negedge clk);
    t_restart_one(2'b00, 7, 0, "R9 async first tick cd=7");
    repeat (3) @(negedge clk);
    t_restart_one(2'b00, 7, 2, "R9 fp-only change cd=7");
    repeat (5) @(negedge clk);
    t_restart_one(2'b01, 3, 0, "R9 sync first tick cd=3");
    t_restart_one(2'b00, 1, 0, "R9 async first tick cd=1");
  endtask

  initial begin
    t_reset();
    t_async_int();
    t_async_frac();
    t_zero_cd();
    t_sync();
    t_spi();
    t_ext();
    t_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule